// File: doc/BRIEF.md
# Multicycle 16-bit Register-Machine Core

This block is a small processor core for a 16-bit, fixed-length instruction set. It holds eight 16-bit general registers, a program counter, an instruction register, a three-flag condition register (negative, zero, positive) and a pair of memory staging registers: one holds the address and one holds the data. Every memory access goes through these two registers. Each instruction steps through a fixed order of phases: fetch, decode, address evaluation, operand fetch, execute and result store. A phase that an instruction does not need is skipped, so the cycle count depends on the opcode.

The core supports register-register and register-immediate add and and, bitwise invert, a load from a base register plus a signed offset, a jump through a register, and a branch on the condition flags. Any other opcode does nothing except advance the program counter. The memory is a single word-addressed port. Its read data returns combinationally in the cycle in which the read strobe is high. A debug view shows the program counter, the flags and all eight registers.

Top module: `cpu16_core`

## Requirements
- R1: A synchronous reset sets the PC to 0x0000, clears all eight registers and sets the flags to Z. The flags appear on `dbg_nzp` as N in bit 2, Z in bit 1 and P in bit 0. Register i appears on `dbg_regs[16*i+15:16*i]`.
- R2: Every instruction raises `mem_rd` in its second cycle, with `mem_addr` equal to the PC at which the instruction starts. From the third cycle on, the PC reads PC+1. `mem_rd` is low in the first cycle.
- R3: Opcode bits [15:12]=0001 is ADD, with the destination in [11:9] and the first source in [8:6]. When bit 5 is 1, the second operand is [4:0] sign-extended; when bit 5 is 0, it is the register named by [2:0]. The instruction takes 7 cycles.
- R4: Opcode 0101 is AND, with the same fields as ADD. Opcode 1001 writes the bitwise inverse of the register named by [8:6] into the register named by [11:9]. Both take 7 cycles.
- R5: Opcode 0110 loads the word at address R[[8:6]] + sign-extended [5:0] into R[[11:9]]. The data read happens in cycle 6 with `mem_rd` high, and the instruction takes 7 cycles.
- R6: After every register write by ADD, AND, invert or load, exactly one flag is set: N if bit 15 of the value is 1, Z if the value is zero, otherwise P.
- R7: Opcode 1100 loads the PC with R[[8:6]] and takes 5 cycles.
- R8: Opcode 0000 tests mask [11:9] (n,z,p) against the flags. If any masked flag is set, the PC becomes PC+1 plus [8:0] sign-extended. The instruction takes 5 cycles. A mask of 000 never branches, and the instruction changes no register and no flag.
- R9: Any other opcode takes 4 cycles and only advances the PC by one.
- R10: `mem_wr` is never asserted by any supported or unsupported instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Word address, driven from the address staging register |
| mem_rd | output | 1 | Read strobe; data is captured at the end of the cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data, driven from the data staging register |
| mem_rdata | input | 16 | Read data, valid in the same cycle as the strobe |
| dbg_pc | output | 16 | Current program counter |
| dbg_nzp | output | 3 | Condition flags {N,Z,P} |
| dbg_regs | output | 128 | All eight registers, R0 in the low word |

## Verification
The hardest cases to bring about are branches whose outcome depends on the flags left by the instruction just before them. The most demanding of these is a countdown loop that branches back twice and then falls through when the counter reaches zero. The program builds that loop, along with a mask-000 branch, a skipped not-taken branch and a jump to a computed address. It also includes a load with a negative offset that reads one of the program's own instruction words. The bench model tracks the phase of every cycle, so the timing of the data read and of the PC increment is checked along with the architectural results.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
  localparam int WORD = 16;

  localparam logic [3:0] OPC_BR  = 4'h0;
  localparam logic [3:0] OPC_ADD = 4'h1;
  localparam logic [3:0] OPC_AND = 4'h5;
  localparam logic [3:0] OPC_LDR = 4'h6;
  localparam logic [3:0] OPC_NOT = 4'h9;
  localparam logic [3:0] OPC_JMP = 4'hC;

  typedef enum logic [2:0] {
    PH_FADR, PH_FRD, PH_FIR, PH_DEC, PH_EVA, PH_OPND, PH_EXEC, PH_STORE
  } phase_e;

  function automatic logic [WORD-1:0] sext5(input logic [4:0] f);
    return {{(WORD-5){f[4]}}, f};
  endfunction

  function automatic logic [WORD-1:0] sext6(input logic [5:0] f);
    return {{(WORD-6){f[5]}}, f};
  endfunction

  function automatic logic [WORD-1:0] sext9(input logic [8:0] f);
    return {{(WORD-9){f[8]}}, f};
  endfunction

  // {N,Z,P} for a value written to a register
  function automatic logic [2:0] flags_of(input logic [WORD-1:0] v);
    if (v[WORD-1]) return 3'b100;
    if (v == '0)   return 3'b010;
    return 3'b001;
  endfunction

  function automatic logic [WORD-1:0] alu_calc(input logic [3:0] op,
                                               input logic [WORD-1:0] a,
                                               input logic [WORD-1:0] b);
    case (op)
      OPC_ADD: return a + b;
      OPC_AND: return a & b;
      default: return ~a;
    endcase
  endfunction

  function automatic logic br_hit(input logic [2:0] mask, input logic [2:0] nzp);
    return |(mask & nzp);
  endfunction
endpackage

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [AW-1:0]      wa,
  input  logic [DW-1:0]      wd,
  input  logic [AW-1:0]      ra,
  input  logic [AW-1:0]      rb,
  output logic [DW-1:0]      qa,
  output logic [DW-1:0]      qb,
  output logic [NREG*DW-1:0] dbg
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign qa = regs[ra];
  assign qb = regs[rb];

  for (genvar g = 0; g < NREG; g++) begin : g_dbg
    assign dbg[g*DW +: DW] = regs[g];
  end
endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
(
  input  logic [3:0]      op,
  input  logic [WORD-1:0] a,
  input  logic [WORD-1:0] b,
  output logic [WORD-1:0] y
);
  assign y = alu_calc(op, a, b);
endmodule

// File: rtl/cpu16_ctrl.sv
module cpu16_ctrl
  import cpu16_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] opcode,
  output phase_e     phase,
  output logic       is_alu,
  output logic       is_ldr,
  output logic       is_jmp,
  output logic       is_br
);
  logic [15:0] dec;
  phase_e      nxt;

  // one line per opcode value
  assign dec    = 16'b1 << opcode;
  assign is_alu = dec[OPC_ADD] | dec[OPC_AND] | dec[OPC_NOT];
  assign is_ldr = dec[OPC_LDR];
  assign is_jmp = dec[OPC_JMP];
  assign is_br  = dec[OPC_BR];

  always_comb begin
    case (phase)
      PH_FADR: nxt = PH_FRD;
      PH_FRD:  nxt = PH_FIR;
      PH_FIR:  nxt = PH_DEC;
      PH_DEC: begin
        if (is_alu)               nxt = PH_OPND;
        else if (is_ldr)          nxt = PH_EVA;
        else if (is_jmp || is_br) nxt = PH_STORE;
        else                      nxt = PH_FADR;
      end
      PH_EVA:  nxt = PH_OPND;
      PH_OPND: nxt = is_ldr ? PH_STORE : PH_EXEC;
      PH_EXEC: nxt = PH_STORE;
      default: nxt = PH_FADR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FADR;
    else     phase <= nxt;
  end
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  output logic [WORD-1:0]    mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [WORD-1:0]    mem_wdata,
  input  logic [WORD-1:0]    mem_rdata,
  output logic [WORD-1:0]    dbg_pc,
  output logic [2:0]         dbg_nzp,
  output logic [NREG*WORD-1:0] dbg_regs
);
  logic [WORD-1:0] pc, ir, mar, mdr, opa, opb, tmp;
  logic [2:0]      nzp;
  phase_e          phase;
  logic            is_alu, is_ldr, is_jmp, is_br;
  logic [WORD-1:0] base_q, src2_q, alu_y, wb_val;
  logic            rf_we;

  // named events used by the checks below
  logic ev_fetch_rd, ev_jmp, ev_br;
  assign ev_fetch_rd = (phase == PH_FRD);
  assign ev_jmp      = (phase == PH_STORE) && is_jmp;
  assign ev_br       = (phase == PH_STORE) && is_br;

  cpu16_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opcode(ir[15:12]), .phase(phase),
    .is_alu(is_alu), .is_ldr(is_ldr), .is_jmp(is_jmp), .is_br(is_br)
  );

  assign rf_we  = (phase == PH_STORE) && (is_alu || is_ldr);
  assign wb_val = is_ldr ? mdr : tmp;

  cpu16_regfile #(.DW(WORD), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .wa(ir[11:9]), .wd(wb_val),
    .ra(ir[8:6]), .rb(ir[2:0]), .qa(base_q), .qb(src2_q), .dbg(dbg_regs)
  );

  cpu16_alu u_alu (.op(ir[15:12]), .a(opa), .b(opb), .y(alu_y));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      ir  <= '0;
      mar <= '0;
      mdr <= '0;
      opa <= '0;
      opb <= '0;
      tmp <= '0;
      nzp <= 3'b010;
    end else begin
      case (phase)
        PH_FADR: mar <= pc;
        PH_FRD: begin
          mdr <= mem_rdata;
          pc  <= pc + 16'd1;
        end
        PH_FIR:  ir  <= mdr;
        PH_EVA:  mar <= base_q + sext6(ir[5:0]);
        PH_OPND: begin
          if (is_ldr) mdr <= mem_rdata;
          else begin
            opa <= base_q;
            opb <= ir[5] ? sext5(ir[4:0]) : src2_q;
          end
        end
        PH_EXEC: tmp <= alu_y;
        PH_STORE: begin
          if (rf_we) nzp <= flags_of(wb_val);
          if (is_jmp) pc <= base_q;
          if (is_br && br_hit(ir[11:9], nzp)) pc <= pc + sext9(ir[8:0]);
        end
        default: ;
      endcase
    end
  end

  assign mem_addr  = mar;
  assign mem_rd    = ev_fetch_rd || ((phase == PH_OPND) && is_ldr);
  assign mem_wr    = 1'b0;
  assign mem_wdata = mdr;
  assign dbg_pc    = pc;
  assign dbg_nzp   = nzp;

  // R6: one flag set at all times
  a_r6_flags_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(nzp) == 1);
  // R2: fetch read uses the PC
  a_r2_fetch_addr: assert property (@(posedge clk) disable iff (rst)
    ev_fetch_rd |-> mem_addr == pc);
  // R2: PC steps by one word after the fetch read
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    ev_fetch_rd |=> pc == $past(pc) + 16'd1);
  // R7: jump target is the base register
  a_r7_jmp_target: assert property (@(posedge clk) disable iff (rst)
    ev_jmp |=> pc == $past(base_q));
  // R8: a branch leaves flags and registers alone
  a_r8_br_keeps_state: assert property (@(posedge clk) disable iff (rst)
    ev_br |=> $stable(nzp) && $stable(dbg_regs));
endmodule

// File: tb/test_cpu16_core.sv
`timescale 1ns/1ps
module test_cpu16_core;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [15:0]  mem_addr, mem_wdata, mem_rdata, dbg_pc;
  logic         mem_rd, mem_wr;
  logic [2:0]   dbg_nzp;
  logic [127:0] dbg_regs;
  logic [15:0]  mem [0:63];

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  assign mem_rdata = mem[mem_addr[5:0]];

  cpu16_core i_cpu16_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dbg_pc(dbg_pc),
    .dbg_nzp(dbg_nzp), .dbg_regs(dbg_regs)
  );

  // model state
  logic [15:0] mreg [8];
  logic [15:0] mpc;
  logic [2:0]  mnzp;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic logic [15:0] e_addr(int d, int a, int b);
    return {4'h1, 3'(d), 3'(a), 3'b000, 3'(b)};
  endfunction
  function automatic logic [15:0] e_addi(int d, int a, int imm);
    return {4'h1, 3'(d), 3'(a), 1'b1, 5'(imm)};
  endfunction
  function automatic logic [15:0] e_andr(int d, int a, int b);
    return {4'h5, 3'(d), 3'(a), 3'b000, 3'(b)};
  endfunction
  function automatic logic [15:0] e_andi(int d, int a, int imm);
    return {4'h5, 3'(d), 3'(a), 1'b1, 5'(imm)};
  endfunction
  function automatic logic [15:0] e_inv(int d, int a);
    return {4'h9, 3'(d), 3'(a), 6'h3F};
  endfunction
  function automatic logic [15:0] e_ld(int d, int b, int off);
    return {4'h6, 3'(d), 3'(b), 6'(off)};
  endfunction
  function automatic logic [15:0] e_br(int mask, int off);
    return {4'h0, 3'(mask), 9'(off)};
  endfunction
  function automatic logic [15:0] e_jmp(int b);
    return {4'hC, 3'b000, 3'(b), 6'b0};
  endfunction

  function automatic logic [2:0] flag3(logic [15:0] v);
    if ($signed(v) < 0) return 3'b100;
    else if (v == 16'd0) return 3'b010;
    else return 3'b001;
  endfunction

  function automatic int cycles_of(logic [15:0] w);
    case (w[15:12])
      4'h1, 4'h5, 4'h9, 4'h6: return 7;
      4'hC, 4'h0: return 5;
      default: return 4;
    endcase
  endfunction

  task automatic check_arch(input string req);
    chk(dbg_pc == mpc, {req, " pc"}, dbg_pc, mpc);
    chk(dbg_nzp == mnzp, {req, " flags"}, {13'b0, dbg_nzp}, {13'b0, mnzp});
    for (int r = 0; r < 8; r++)
      chk(dbg_regs[16*r +: 16] == mreg[r], {req, " reg"}, dbg_regs[16*r +: 16], mreg[r]);
  endtask

  function automatic string req_of(logic [15:0] w);
    case (w[15:12])
      4'h1: return "R3";
      4'h5, 4'h9: return "R4";
      4'h6: return "R5";
      4'hC: return "R7";
      4'h0: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin : main
    logic [15:0] w, ea, v, npc;
    int len;
    for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
    mem[0]  = e_addi(1, 0, 5);      // R1=5
    mem[1]  = e_addi(2, 1, -7);     // R2=-2
    mem[2]  = e_addr(3, 1, 2);      // R3=3
    mem[3]  = e_andi(4, 3, 0);      // R4=0
    mem[4]  = e_inv(5, 2);          // R5=1
    mem[5]  = e_andr(6, 1, 3);      // R6=1
    mem[6]  = e_ld(7, 1, 20);       // R7=mem[25]
    mem[7]  = e_ld(0, 3, -1);       // R0=mem[2]
    mem[8]  = e_br(3'b010, 5);      // not taken
    mem[9]  = e_br(3'b001, 3);      // taken -> 13
    mem[10] = e_addi(1, 1, 1);
    mem[11] = e_addi(1, 1, 1);
    mem[12] = e_addi(1, 1, 1);
    mem[13] = 16'h3123;             // unsupported
    mem[14] = e_br(3'b000, 3);      // never taken
    mem[15] = e_addi(4, 4, 0);      // Z
    mem[16] = e_br(3'b010, 2);      // taken -> 19
    mem[17] = e_addi(1, 1, 1);
    mem[18] = e_addi(1, 1, 1);
    mem[19] = e_andi(2, 2, -1);     // -2
    mem[20] = e_addi(3, 3, -1);     // loop
    mem[21] = e_br(3'b001, -2);     // back to 20
    mem[22] = e_addi(6, 4, 15);
    mem[23] = e_addr(6, 6, 6);      // 30
    mem[24] = e_jmp(6);
    mem[25] = 16'h8001;
    mem[30] = e_inv(1, 7);
    mem[31] = 16'hF0F0;             // unsupported
    mem[32] = e_br(3'b111, -33);    // always taken -> 0

    for (int r = 0; r < 8; r++) mreg[r] = 16'h0;
    mpc = 16'h0;
    mnzp = 3'b010;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_arch("R1");
    chk(mem_rd == 1'b0, "R1 rd after reset", {15'b0, mem_rd}, 16'h0);

    // run until the always-taken branch at 32 returns to 0
    for (int n = 0; n < 60; n++) begin
      w   = mem[mpc[5:0]];
      len = cycles_of(w);
      ea  = mreg[w[8:6]] + {{10{w[5]}}, w[5:0]};
      for (int k = 1; k <= len; k++) begin
        if (k == 2) begin
          chk(mem_rd == 1'b1, "R2 fetch strobe", {15'b0, mem_rd}, 16'h1);
          chk(mem_addr == mpc, "R2 fetch addr", mem_addr, mpc);
        end else if (k == 6 && w[15:12] == 4'h6) begin
          chk(mem_rd == 1'b1, "R5 load strobe", {15'b0, mem_rd}, 16'h1);
          chk(mem_addr == ea, "R5 load addr", mem_addr, ea);
        end else begin
          chk(mem_rd == 1'b0, {req_of(w), " no read"}, {15'b0, mem_rd}, 16'h0);
        end
        if (k == 3) chk(dbg_pc == mpc + 16'd1, "R2 pc+1", dbg_pc, mpc + 16'd1);
        chk(mem_wr == 1'b0, "R10 no write", {15'b0, mem_wr}, 16'h0);
        @(negedge clk);
      end
      // model update
      npc = mpc + 16'd1;
      case (w[15:12])
        4'h1: begin
          v = mreg[w[8:6]] + (w[5] ? {{11{w[4]}}, w[4:0]} : mreg[w[2:0]]);
          mreg[w[11:9]] = v; mnzp = flag3(v);
        end
        4'h5: begin
          v = mreg[w[8:6]] & (w[5] ? {{11{w[4]}}, w[4:0]} : mreg[w[2:0]]);
          mreg[w[11:9]] = v; mnzp = flag3(v);
        end
        4'h9: begin
          v = ~mreg[w[8:6]];
          mreg[w[11:9]] = v; mnzp = flag3(v);
        end
        4'h6: begin
          v = mem[ea[5:0]];
          mreg[w[11:9]] = v; mnzp = flag3(v);
        end
        4'hC: npc = mreg[w[8:6]];
        4'h0: if ((w[11:9] & mnzp) != 3'b000) npc = npc + {{7{w[8]}}, w[8:0]};
        default: ;
      endcase
      mpc = npc;
      check_arch({req_of(w), " R6"});
      if (mpc == 16'h0) break;
    end
    chk(mpc == 16'h0, "R8 program end", mpc, 16'h0);

    // second reset with nonzero state
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int r = 0; r < 8; r++) mreg[r] = 16'h0;
    mpc = 16'h0;
    mnzp = 3'b010;
    check_arch("R1 rerun");
    finish_run();
  end
endmodule